// File: doc/BRIEF.md
# Prescaled Wrap-Around Timer

This block is a 16-bit up-counting timer that sits on a simple 32-bit register bus. Software chooses a power-of-two divide ratio, a top value and a restart value, then starts the counter. The counter climbs from the restart value to the top value and returns to the restart value. Every return sets a sticky wrap flag. The flag can also drive a level interrupt output.

The top and restart values are written into holding registers. The counter uses them only after the count source has been switched off, so software can reprogram the period without tearing a period that is already running. A write of any data to the count register reloads the counter from the active restart value. The usual sequence is therefore: stop, write top value, force reload, start. A period of N counts uses a top value of N-1 and a restart value of 0.

The bus is a single-cycle request interface. `req_i` with `we_i` high is a write and takes effect at the next rising clock edge. `req_i` with `we_i` low is a read, and `rdata_o` is valid in the same cycle.

Top module: `prescaled_wrap_timer`

## Requirements
- R1: After reset every register reads 0 and `irq_o` is 0: control, count, top value and restart value.
- R2: Register byte addresses are control 0x00, count 0x04, top value 0x08 and restart value 0x4C. Control holds the divide exponent in bits [2:0], the count source in bits [4:3], the interrupt enable in bit 6 and the wrap flag in bit 7. Bit 5 and bits [31:8] read 0. Count, top value and restart value keep 16 bits and read zero-extended.
- R3: The counter advances only while the count source field is 1. For source values 0, 2 and 3 the count holds.
- R4: With exponent E, the counter advances once every 2^E clock cycles. The first advance comes 2^E cycles after the start write.
- R5: On an advance, the counter increments while below the top value. When it equals the top value, the advance reloads it with the restart value.
- R6: The wrap flag sets on the advance that moves the counter from the top value to the restart value.
- R7: A write of any data to the count register loads the active restart value, and the written data is discarded.
- R8: Writes to top value and restart value go to holding registers. The values that are read back and used are the active ones. Each cycle in which the source field is 0, the active registers copy the holding registers, and they take effect from the next cycle.
- R9: The wrap flag clears only when a control read that sees the flag set is followed by a control write with bit 7 at 0. Any control write ends this armed state. Writing 1 to bit 7 never sets or clears the flag.
- R10: If a wrap and a clear fall in the same cycle, the flag stays set.
- R11: `irq_o` is the registered AND of the wrap flag and the enable, one cycle behind them. It stays high until the flag is cleared or the enable is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus and timer clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte address of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the request cycle |
| irq_o | output | 1 | Wrap interrupt, level high |

## Verification
Assertions check these on every cycle: a stopped counter holds unless reloaded, each non-wrapping advance adds exactly one, each wrap lands on the restart value and sets the flag, the active period registers hold while the source is on, and the interrupt is low whenever the flag was low. The bench scenarios cover what needs a sequence of accesses: the divide rates, the read-then-write clear handshake, a clear that collides with a wrap, the hold-off of buffered writes until the counter is stopped, and that the data written to the count register is discarded.

// File: rtl/wrap_timer_pkg.sv
package wrap_timer_pkg;
  localparam int unsigned REG_CTRL  = 8'h00;
  localparam int unsigned REG_COUNT = 8'h04;
  localparam int unsigned REG_TOP   = 8'h08;
  localparam int unsigned REG_START = 8'h4C;

  localparam int unsigned BIT_IE    = 6;
  localparam int unsigned BIT_FLAG  = 7;
  localparam int unsigned SRC_LSB   = 3;

  typedef enum logic [1:0] {
    SRC_OFF  = 2'd0,
    SRC_SYS  = 2'd1,
    SRC_RSV2 = 2'd2,
    SRC_RSV3 = 2'd3
  } src_e;
endpackage

// File: rtl/wrap_timer_prescale.sv
module wrap_timer_prescale #(
  parameter int unsigned PS_W = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            run_i,
  input  logic [PS_W-1:0] exp_i,
  output logic            tick_o
);
  localparam int unsigned DIV_W = (1 << PS_W) - 1;

  logic [DIV_W-1:0] pre_q, pre_d, mask;

  always_comb begin
    mask   = ~({DIV_W{1'b1}} << exp_i);
    tick_o = run_i && ((pre_q & mask) == mask);
    pre_d  = run_i ? pre_q + 1'b1 : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pre_q <= '0;
    else         pre_q <= pre_d;
  end
endmodule

// File: rtl/wrap_timer_counter.sv
module wrap_timer_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] top_i,
  input  logic [CNT_W-1:0] start_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             at_top;

  always_comb begin
    at_top = (cnt_q == top_i);
    wrap_o = tick_i && !load_i && at_top;
    cnt_d  = cnt_q;
    if (load_i)      cnt_d = start_i;
    else if (tick_i) cnt_d = at_top ? start_i : cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  assert_wrap_reload_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> (cnt_q == $past(start_i)));
  assert_step_by_one_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !load_i && !at_top) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/wrap_timer_regs.sv
module wrap_timer_regs
  import wrap_timer_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned PS_W   = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              wrap_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [PS_W-1:0]   exp_o,
  output logic              run_o,
  output logic [CNT_W-1:0]  top_o,
  output logic [CNT_W-1:0]  start_o,
  output logic              load_o,
  output logic              irq_o
);
  logic [PS_W-1:0]  exp_q, exp_d;
  src_e             src_q, src_d;
  logic             ie_q, ie_d, flag_q, flag_d, armed_q, armed_d, irq_q, irq_d;
  logic [CNT_W-1:0] top_sh_q, top_sh_d, top_q, top_d;
  logic [CNT_W-1:0] st_sh_q, st_sh_d, st_q, st_d;
  logic             wr_ctrl, rd_ctrl, wr_top, wr_start, clear;
  logic             unused_wdata;

  assign unused_wdata = ^wdata_i;

  always_comb begin
    wr_ctrl  = req_i && we_i && (addr_i == ADDR_W'(REG_CTRL));
    rd_ctrl  = req_i && !we_i && (addr_i == ADDR_W'(REG_CTRL));
    wr_top   = req_i && we_i && (addr_i == ADDR_W'(REG_TOP));
    wr_start = req_i && we_i && (addr_i == ADDR_W'(REG_START));
    load_o   = req_i && we_i && (addr_i == ADDR_W'(REG_COUNT));
    clear    = wr_ctrl && armed_q && !wdata_i[BIT_FLAG];

    exp_d    = wr_ctrl ? wdata_i[PS_W-1:0] : exp_q;
    src_d    = wr_ctrl ? src_e'(wdata_i[SRC_LSB +: 2]) : src_q;
    ie_d     = wr_ctrl ? wdata_i[BIT_IE] : ie_q;
    flag_d   = wrap_i || (flag_q && !clear);
    if (wr_ctrl)                armed_d = 1'b0;
    else if (rd_ctrl && flag_q) armed_d = 1'b1;
    else                        armed_d = armed_q;
    irq_d    = flag_q && ie_q;

    top_sh_d = wr_top   ? wdata_i[CNT_W-1:0] : top_sh_q;
    st_sh_d  = wr_start ? wdata_i[CNT_W-1:0] : st_sh_q;
    top_d    = (src_q == SRC_OFF) ? top_sh_q : top_q;
    st_d     = (src_q == SRC_OFF) ? st_sh_q  : st_q;

    rdata_o  = '0;
    if (req_i && !we_i) begin
      unique case (addr_i)
        ADDR_W'(REG_CTRL): begin
          rdata_o[PS_W-1:0]       = exp_q;
          rdata_o[SRC_LSB +: 2]   = src_q;
          rdata_o[BIT_IE]         = ie_q;
          rdata_o[BIT_FLAG]       = flag_q;
        end
        ADDR_W'(REG_COUNT): rdata_o[CNT_W-1:0] = cnt_i;
        ADDR_W'(REG_TOP):   rdata_o[CNT_W-1:0] = top_q;
        ADDR_W'(REG_START): rdata_o[CNT_W-1:0] = st_q;
        default:            rdata_o = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exp_q    <= '0;
      src_q    <= SRC_OFF;
      ie_q     <= 1'b0;
      flag_q   <= 1'b0;
      armed_q  <= 1'b0;
      irq_q    <= 1'b0;
      top_sh_q <= '0;
      top_q    <= '0;
      st_sh_q  <= '0;
      st_q     <= '0;
    end else begin
      exp_q    <= exp_d;
      src_q    <= src_d;
      ie_q     <= ie_d;
      flag_q   <= flag_d;
      armed_q  <= armed_d;
      irq_q    <= irq_d;
      top_sh_q <= top_sh_d;
      top_q    <= top_d;
      st_sh_q  <= st_sh_d;
      st_q     <= st_d;
    end
  end

  assign exp_o   = exp_q;
  assign run_o   = (src_q == SRC_SYS);
  assign top_o   = top_q;
  assign start_o = st_q;
  assign irq_o   = irq_q;

  assert_wrap_sets_flag_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_i |=> flag_q);
  assert_active_held_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_q != SRC_OFF) |=> ($stable(top_q) && $stable(st_q)));
  assert_irq_needs_flag_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flag_q |=> !irq_q);
  assert_no_blind_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !armed_q) |=> flag_q);
endmodule

// File: rtl/prescaled_wrap_timer.sv
module prescaled_wrap_timer #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned PS_W   = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  logic [1:0]       rst_sync_q;
  logic             rst_n;
  logic             run, tick, load, wrap;
  logic [PS_W-1:0]  exp;
  logic [CNT_W-1:0] top, start, cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  wrap_timer_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .PS_W(PS_W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_n), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .wrap_i(wrap), .cnt_i(cnt), .rdata_o(rdata_o), .exp_o(exp),
    .run_o(run), .top_o(top), .start_o(start), .load_o(load), .irq_o(irq_o));

  wrap_timer_prescale #(.PS_W(PS_W)) u_pre (
    .clk_i(clk_i), .rst_ni(rst_n), .run_i(run), .exp_i(exp), .tick_o(tick));

  wrap_timer_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_n), .tick_i(tick), .load_i(load), .top_i(top),
    .start_i(start), .cnt_o(cnt), .wrap_o(wrap));

  assert_stopped_holds_R3: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!run && !load) |=> $stable(cnt));
endmodule

// File: tb/tb_prescaled_wrap_timer.sv
module tb_prescaled_wrap_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int          errors = 0, checks = 0;
  logic [31:0] v, v2;

  localparam logic [7:0] A_CTRL = 8'h00, A_CNT = 8'h04, A_TOP = 8'h08, A_ST = 8'h4C;

  always #5 clk = ~clk;

  prescaled_wrap_timer dut (.clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // All tasks start and end at a falling edge.
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    req = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    rd(A_CTRL, v); check("R1 ctrl", v, 0);
    rd(A_CNT, v);  check("R1 count", v, 0);
    rd(A_TOP, v);  check("R1 top", v, 0);
    rd(A_ST, v);   check("R1 start", v, 0);
    check("R1 irq", {31'b0, irq}, 0);
  endtask

  task automatic t_basic_wrap;
    wr(A_TOP, 32'hFFFF_0005);
    wr(A_CNT, 32'h0000_00AA);
    wr(A_CTRL, 32'h08);
    for (int i = 0; i < 7; i++) begin
      rd(A_CNT, v); check("R5 count sequence", v, i % 6);
    end
    rd(A_CTRL, v); check("R6 flag after wrap, R2 ctrl layout", v, 32'h88);
  endtask

  task automatic t_prescale;
    wr(A_CTRL, 32'h00);
    wr(A_CNT, 32'h0);
    wr(A_CTRL, 32'h0A);
    for (int i = 0; i < 9; i++) begin
      rd(A_CNT, v); check("R4 divide by 4", v, i / 4);
    end
  endtask

  task automatic t_buffer;
    wr(A_TOP, 32'h3);
    idle(2);
    rd(A_TOP, v); check("R8 top held while running", v, 5);
    wr(A_CTRL, 32'h00);
    idle(1);
    rd(A_TOP, v); check("R8 top taken when stopped", v, 3);
  endtask

  task automatic t_stop_hold;
    rd(A_CNT, v); idle(5);
    rd(A_CNT, v2); check("R3 source 0 holds", v2, v);
    wr(A_CTRL, 32'h10);
    rd(A_CNT, v); idle(4);
    rd(A_CNT, v2); check("R3 source 2 holds", v2, v);
  endtask

  task automatic t_load;
    wr(A_CTRL, 32'h00);
    wr(A_ST, 32'h0001_1234);
    idle(1);
    wr(A_CNT, 32'hFFFF);
    rd(A_CNT, v); check("R7 count write loads start", v, 32'h1234);
    rd(A_ST, v);  check("R2 start 16-bit readback", v, 32'h1234);
  endtask

  task automatic t_start_wrap;
    wr(A_ST, 32'h2);
    wr(A_TOP, 32'h4);
    idle(1);
    wr(A_CNT, 32'h0);
    wr(A_CTRL, 32'h08);
    rd(A_CNT, v); check("R5 from start", v, 2);
    rd(A_CNT, v); check("R5 step", v, 3);
    rd(A_CNT, v); check("R5 at top", v, 4);
    rd(A_CNT, v); check("R5 reload to start", v, 2);
    wr(A_CTRL, 32'h80);
    rd(A_CTRL, v); check("R6 flag after start wrap", v, 32'h80);
  endtask

  task automatic t_flag_clear;
    wr(A_CTRL, 32'h80);
    wr(A_CTRL, 32'h00);
    rd(A_CTRL, v); check("R9 write 0 without read keeps flag", v, 32'h80);
    wr(A_CTRL, 32'h00);
    rd(A_CTRL, v); check("R9 read then write 0 clears", v, 32'h00);
    wr(A_CTRL, 32'h80);
    rd(A_CTRL, v); check("R9 write 1 does not set", v, 32'h00);
  endtask

  task automatic t_collision;
    wr(A_ST, 32'h0);
    wr(A_TOP, 32'h3);
    idle(1);
    wr(A_CNT, 32'h0);
    wr(A_CTRL, 32'h08);
    idle(5);
    rd(A_CTRL, v); check("R6 flag set before collision", v, 32'h88);
    idle(1);
    wr(A_CTRL, 32'h08);
    rd(A_CTRL, v); check("R10 wrap beats clear", v, 32'h88);
  endtask

  task automatic t_irq;
    wr(A_CTRL, 32'h80);
    check("R11 irq low without enable", {31'b0, irq}, 0);
    wr(A_CTRL, 32'hC0);
    check("R11 irq one cycle late", {31'b0, irq}, 0);
    idle(1);
    check("R11 irq high", {31'b0, irq}, 1);
    rd(A_CTRL, v);
    wr(A_CTRL, 32'h40);
    check("R11 irq still high at clear edge", {31'b0, irq}, 1);
    idle(1);
    check("R11 irq low after clear", {31'b0, irq}, 0);
  endtask

  initial begin
    fork
      begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        t_reset;
        t_basic_wrap;
        t_prescale;
        t_buffer;
        t_stop_hold;
        t_load;
        t_start_wrap;
        t_flag_clear;
        t_collision;
        t_irq;
      end
      begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule